// File: doc/BRIEF.md
# Reset and NOP Bus Sequencer

This block is a cycle-accurate model of what an 8-bit microprocessor shows on its external pins from reset release until it runs a stream of no-operation opcodes. It receives a phase-0 clock level, an active-low processor reset and an 8-bit read-data bus. It produces the two derived phase clocks, a 16-bit address, an opcode-fetch strobe, a read/write line, an active-low vector-pull strobe and an error flag. It suits a pin-level tester or a board bring-up fixture, where a known-good bus trace has to be produced or compared against.

Everything runs on one fabric clock `clk` with a synchronous active-high `rst`. The phase-0 input is sampled on `clk`. Each bus cycle runs from one falling phase-0 edge to the next, and the address and strobes for a cycle are registered on the first `clk` edge after phase-0 falls. Read data is captured on that same edge, which closes the previous cycle. The parameter `CMOS_VAR` selects one of two device families. With 0, the three stack cycles of the reset sequence are writes. With 1, they stay reads, one extra dummy read comes before them, and the vector-pull strobe is active.

Top module: `cpu_bus_seq`

## Requirements
- R1: While `res_n_i` is low, `phi2_o` follows `phi0_i` one clock late and `phi1_o` is its inverse. Within one clock of `res_n_i` going low, `sync_o`=0, `rw_o`=1 and `err_o`=0.
- R2: While `rst` is high, the outputs are `addr_o`=16'h0000, `sync_o`=0, `rw_o`=1, `vp_n_o`=1, `err_o`=0, `phi1_o`=1 and `phi2_o`=0.
- R3: The address and strobes take their new value on the first clock after `phi0_i` falls. They do not change at any other time while `res_n_i` is high.
- R4: In the first bus cycle after `res_n_i` rises, `sync_o`=1 and `rw_o`=1. In the second bus cycle, `sync_o`=0 and `rw_o`=1.
- R5: Three stack cycles follow, at addresses {8'h01,SP}, {8'h01,SP-1} and {8'h01,SP-2}. SP starts at `SP_RESET` (default 8'hFD) and keeps its decremented value into the next reset sequence.
- R6: With `CMOS_VAR`=0, `rw_o`=0 in the three stack cycles. With `CMOS_VAR`=1, `rw_o`=1 in the stack cycles, and one extra read cycle comes between the second cycle and the first stack cycle.
- R7: After the stack cycles, the low vector byte is read at 16'hFFFC and the high byte at 16'hFFFD. The byte on `data_i` at the end of each of these cycles is loaded into the program counter.
- R8: With `CMOS_VAR`=1, `vp_n_o`=0 in exactly the two vector cycles. With `CMOS_VAR`=0, `vp_n_o` stays 1.
- R9: When opcode 8'hEA is fetched at PC (`sync_o`=1), the next cycle reads PC+1 with `sync_o`=0, and the next fetch is at PC+1. The program counter carries across a page boundary.
- R10: Any other fetched opcode enters an error state. In that state `err_o`=1, `addr_o` holds the fetch address, `sync_o`=0 and `rw_o`=1, until `res_n_i` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| phi0_i | input | 1 | Phase-0 clock level, synchronous to clk |
| res_n_i | input | 1 | Active-low processor reset |
| data_i | input | 8 | Read data bus |
| phi1_o | output | 1 | Phase-1 clock (inverse of phase 0) |
| phi2_o | output | 1 | Phase-2 clock (copy of phase 0) |
| addr_o | output | 16 | Address bus |
| sync_o | output | 1 | High in opcode-fetch cycles |
| rw_o | output | 1 | 1 = read, 0 = write |
| vp_n_o | output | 1 | Active-low vector-pull strobe |
| err_o | output | 1 | Unsupported opcode was fetched |

## Verification
Every bus-cycle result is due on the first clock after phase 0 falls. Each bench bus cycle therefore samples the address once, one falling clock edge after driving phase 0 low, and samples again two clocks into the high phase. The first sample proves the one-clock latency and the second proves the value stays put. The reset quietening is due one clock after the reset pin drops, and it is sampled at the next falling clock edge. Read data is driven at the start of the high phase and held past the next falling phase-0 edge, so it is stable when the block captures it.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_BOOT0,
    ST_BOOT1,
    ST_PAD,
    ST_STK0,
    ST_STK1,
    ST_STK2,
    ST_VECL,
    ST_VECH,
    ST_FETCH,
    ST_NOP2,
    ST_ERR
  } bus_state_e;

  typedef struct packed {
    logic sync;
    logic rw;
    logic vp_n;
    logic err;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{sync: 1'b0, rw: 1'b1, vp_n: 1'b1, err: 1'b0};

endpackage

// File: rtl/cpu_phase_gen.sv
module cpu_phase_gen (
  input  logic clk,
  input  logic rst,
  input  logic phi0_i,
  output logic phi1_o,
  output logic phi2_o,
  output logic fall_o
);

  logic phi0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi0_q <= 1'b0;
      phi2_o <= 1'b0;
      phi1_o <= 1'b1;
    end else begin
      phi0_q <= phi0_i;
      phi2_o <= phi0_i;
      phi1_o <= ~phi0_i;
    end
  end

  // one-cycle pulse when phase 0 has just dropped
  assign fall_o = phi0_q & ~phi0_i;

endmodule

// File: rtl/cpu_bus_fsm.sv
module cpu_bus_fsm
  import cpu_bus_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 2 * DATA_W,
  parameter bit              CMOS_VAR   = 1'b0,
  parameter logic [DATA_W-1:0] SP_RESET   = 8'hFD,
  parameter logic [DATA_W-1:0] NOP_OPCODE = 8'hEA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic              res_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output bus_ctl_t          ctl_o
);

  localparam logic [ADDR_W-1:0] STK_BASE = ADDR_W'(1) << DATA_W;
  localparam logic [ADDR_W-1:0] VEC_LO   = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VEC_HI   = ~ADDR_W'(2);

  bus_state_e        state, state_nx;
  logic [ADDR_W-1:0] pc, pc_nx, addr_nx;
  logic [DATA_W-1:0] sp, sp_nx;
  bus_ctl_t          ctl_nx;

  logic pad_en;
  logic stk_rw;
  logic vp_en;

  generate
    if (CMOS_VAR) begin : g_cmos
      assign pad_en = 1'b1;
      assign stk_rw = 1'b1;
      assign vp_en  = 1'b1;
    end else begin : g_nmos
      assign pad_en = 1'b0;
      assign stk_rw = 1'b0;
      assign vp_en  = 1'b0;
    end
  endgenerate

  // next bus cycle, evaluated for the falling phase-0 edge
  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    sp_nx    = sp;
    unique case (state)
      ST_HOLD:  state_nx = ST_BOOT0;
      ST_BOOT0: state_nx = ST_BOOT1;
      ST_BOOT1: state_nx = pad_en ? ST_PAD : ST_STK0;
      ST_PAD:   state_nx = ST_STK0;
      ST_STK0: begin
        state_nx = ST_STK1;
        sp_nx    = sp - DATA_W'(1);
      end
      ST_STK1: begin
        state_nx = ST_STK2;
        sp_nx    = sp - DATA_W'(1);
      end
      ST_STK2: begin
        state_nx = ST_VECL;
        sp_nx    = sp - DATA_W'(1);
      end
      ST_VECL: begin
        state_nx = ST_VECH;
        pc_nx[DATA_W-1:0] = data_i;
      end
      ST_VECH: begin
        state_nx = ST_FETCH;
        pc_nx[ADDR_W-1:DATA_W] = data_i;
      end
      ST_FETCH: begin
        if (data_i == NOP_OPCODE) begin
          state_nx = ST_NOP2;
          pc_nx    = pc + ADDR_W'(1);
        end else begin
          state_nx = ST_ERR;
        end
      end
      ST_NOP2:  state_nx = ST_FETCH;
      ST_ERR:   state_nx = ST_ERR;
      default:  state_nx = ST_HOLD;
    endcase
  end

  // pin values for the cycle being entered
  always_comb begin
    addr_nx = pc_nx;
    ctl_nx  = CTL_IDLE;
    unique case (state_nx)
      ST_STK0, ST_STK1, ST_STK2: begin
        addr_nx   = STK_BASE | ADDR_W'(sp_nx);
        ctl_nx.rw = stk_rw;
      end
      ST_VECL: begin
        addr_nx     = VEC_LO;
        ctl_nx.vp_n = ~vp_en;
      end
      ST_VECH: begin
        addr_nx     = VEC_HI;
        ctl_nx.vp_n = ~vp_en;
      end
      ST_BOOT0, ST_FETCH: ctl_nx.sync = 1'b1;
      ST_ERR:             ctl_nx.err  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HOLD;
      pc     <= '0;
      sp     <= SP_RESET;
      addr_o <= '0;
      ctl_o  <= CTL_IDLE;
    end else if (!res_n_i) begin
      state  <= ST_HOLD;
      addr_o <= pc;
      ctl_o  <= CTL_IDLE;
    end else if (fall_i) begin
      state  <= state_nx;
      pc     <= pc_nx;
      sp     <= sp_nx;
      addr_o <= addr_nx;
      ctl_o  <= ctl_nx;
    end
  end

endmodule

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
  import cpu_bus_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 2 * DATA_W,
  parameter bit                CMOS_VAR   = 1'b0,
  parameter logic [DATA_W-1:0] SP_RESET   = 8'hFD,
  parameter logic [DATA_W-1:0] NOP_OPCODE = 8'hEA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi0_i,
  input  logic              res_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sync_o,
  output logic              rw_o,
  output logic              vp_n_o,
  output logic              err_o
);

  logic     fall;
  bus_ctl_t ctl;

  cpu_phase_gen u_phase (
    .clk    (clk),
    .rst    (rst),
    .phi0_i (phi0_i),
    .phi1_o (phi1_o),
    .phi2_o (phi2_o),
    .fall_o (fall)
  );

  cpu_bus_fsm #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CMOS_VAR   (CMOS_VAR),
    .SP_RESET   (SP_RESET),
    .NOP_OPCODE (NOP_OPCODE)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .fall_i  (fall),
    .res_n_i (res_n_i),
    .data_i  (data_i),
    .addr_o  (addr_o),
    .ctl_o   (ctl)
  );

  assign sync_o = ctl.sync;
  assign rw_o   = ctl.rw;
  assign vp_n_o = ctl.vp_n;
  assign err_o  = ctl.err;

endmodule

// File: rtl/cpu_bus_seq_chk.sv
module cpu_bus_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              phi0_i,
  input logic              res_n_i,
  input logic              phi1_o,
  input logic              phi2_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sync_o,
  input logic              rw_o,
  input logic              vp_n_o,
  input logic              err_o
);

  // R1
  phase_pair_chk: assert property (@(posedge clk) disable iff (rst)
    phi1_o != phi2_o);

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_n_i |=> (!sync_o && rw_o && !err_o));

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (res_n_i && !($past(phi0_i) && !phi0_i)) |=> $stable(addr_o));

  // R6
  write_page_chk: assert property (@(posedge clk) disable iff (rst)
    !rw_o |-> (addr_o[ADDR_W-1:8] == 8'h01));

  // R8
  vector_pull_chk: assert property (@(posedge clk) disable iff (rst)
    !vp_n_o |-> (addr_o[ADDR_W-1:1] == 15'h7FFE));

  // R9
  fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (rw_o && !err_o));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && res_n_i) |=> err_o);

endmodule

bind cpu_bus_seq cpu_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .phi0_i  (phi0_i),
  .res_n_i (res_n_i),
  .phi1_o  (phi1_o),
  .phi2_o  (phi2_o),
  .addr_o  (addr_o),
  .sync_o  (sync_o),
  .rw_o    (rw_o),
  .vp_n_o  (vp_n_o),
  .err_o   (err_o)
);

// File: tb/tb_cpu_bus_seq.sv
module tb_cpu_bus_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi0 = 1'b1;
  logic res_n = 1'b0;
  logic [7:0] dn = 8'h00;
  logic [7:0] dc = 8'h00;

  logic        p1_n, p2_n, s_n, r_n, v_n, e_n;
  logic        p1_c, p2_c, s_c, r_c, v_c, e_c;
  logic [15:0] addr_n, addr_c;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_bus_seq #(.CMOS_VAR(1'b0)) dut (
    .clk(clk), .rst(rst), .phi0_i(phi0), .res_n_i(res_n), .data_i(dn),
    .phi1_o(p1_n), .phi2_o(p2_n), .addr_o(addr_n), .sync_o(s_n),
    .rw_o(r_n), .vp_n_o(v_n), .err_o(e_n)
  );

  cpu_bus_seq #(.CMOS_VAR(1'b1)) dut_c (
    .clk(clk), .rst(rst), .phi0_i(phi0), .res_n_i(res_n), .data_i(dc),
    .phi1_o(p1_c), .phi2_o(p2_c), .addr_o(addr_c), .sync_o(s_c),
    .rw_o(r_c), .vp_n_o(v_c), .err_o(e_c)
  );

  // captures per bus cycle: index 0 = write-stack family, 1 = read-stack family
  logic [15:0] a_lo [2];
  logic [15:0] a_hi [2];
  logic s_hi [2];
  logic r_hi [2];
  logic v_hi [2];
  logic e_hi [2];
  logic p1_lo [2];
  logic p2_lo [2];
  logic p1_hi [2];
  logic p2_hi [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one bus cycle: phase 0 low for 3 clocks, high for 4
  task automatic tick(input logic [7:0] d_n, input logic [7:0] d_c);
    @(negedge clk); phi0 = 1'b0;
    @(negedge clk);
    a_lo[0] = addr_n; a_lo[1] = addr_c;
    @(negedge clk);
    p1_lo[0] = p1_n; p2_lo[0] = p2_n; p1_lo[1] = p1_c; p2_lo[1] = p2_c;
    @(negedge clk); dn = d_n; dc = d_c; phi0 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    a_hi[0] = addr_n; s_hi[0] = s_n; r_hi[0] = r_n; v_hi[0] = v_n; e_hi[0] = e_n;
    a_hi[1] = addr_c; s_hi[1] = s_c; r_hi[1] = r_c; v_hi[1] = v_c; e_hi[1] = e_c;
    p1_hi[0] = p1_n; p2_hi[0] = p2_n; p1_hi[1] = p1_c; p2_hi[1] = p2_c;
    @(negedge clk);
  endtask

  function automatic logic [7:0] data_for(input bit cm, input int k, input logic [15:0] vec, input bit bad);
    int off = cm ? 1 : 0;
    if (k == 5 + off) return vec[7:0];
    if (k == 6 + off) return vec[15:8];
    if (bad && k == 7 + off) return 8'h00;
    return 8'hEA;
  endfunction

  function automatic string req_of(input bit cm, input int k, input bit bad);
    int off = cm ? 1 : 0;
    if (k < 2 + off) return "R4";
    if (k < 5 + off) return "R5";
    if (k < 7 + off) return "R7";
    if (bad && k > 7 + off) return "R10";
    return "R9";
  endfunction

  task automatic expect_cyc(input bit cm, input int k, input logic [15:0] vec, input logic [7:0] sp0,
                            input bit bad, output logic [15:0] a, output logic s, output logic r,
                            output logic v, output logic e, output bit ca);
    int off = cm ? 1 : 0;
    int j;
    a = 16'h0000; s = 1'b0; r = 1'b1; v = 1'b1; e = 1'b0; ca = 1'b1;
    if (k < 2 + off) begin
      s = (k == 0); ca = 1'b0;
    end else if (k < 5 + off) begin
      a = {8'h01, sp0 - 8'(k - 2 - off)}; r = cm;
    end else if (k == 5 + off) begin
      a = 16'hFFFC; v = !cm;
    end else if (k == 6 + off) begin
      a = 16'hFFFD; v = !cm;
    end else begin
      j = k - 7 - off;
      if (bad && j > 0) begin
        a = vec; e = 1'b1;
      end else begin
        a = vec + 16'(j / 2) + 16'(j % 2);
        s = (j % 2 == 0);
      end
    end
  endtask

  // runs a sequence from reset release; res_n must already be high with phase 0 high
  task automatic run_boot(input logic [15:0] vn, input logic [15:0] vc, input logic [7:0] spn,
                          input logic [7:0] spc, input int ncyc, input bit bad);
    logic [15:0] ea;
    logic es, er, ev, ee;
    bit ca;
    string rq;
    for (int k = 0; k < ncyc; k++) begin
      tick(data_for(1'b0, k, vn, bad), data_for(1'b1, k, vc, bad));
      for (int d = 0; d < 2; d++) begin
        expect_cyc(d == 1, k, (d == 1) ? vc : vn, (d == 1) ? spc : spn, bad, ea, es, er, ev, ee, ca);
        rq = req_of(d == 1, k, bad);
        if (ca) begin
          chk(rq, $sformatf("addr dut%0d cyc%0d", d, k), 32'(a_hi[d]), 32'(ea));
          chk("R3", $sformatf("addr one clock after fall dut%0d cyc%0d", d, k), 32'(a_lo[d]), 32'(ea));
        end
        chk(rq, $sformatf("sync dut%0d cyc%0d", d, k), 32'(s_hi[d]), 32'(es));
        chk((rq == "R5") ? "R6" : rq, $sformatf("rw dut%0d cyc%0d", d, k), 32'(r_hi[d]), 32'(er));
        chk("R8", $sformatf("vp_n dut%0d cyc%0d", d, k), 32'(v_hi[d]), 32'(ev));
        chk(rq, $sformatf("err dut%0d cyc%0d", d, k), 32'(e_hi[d]), 32'(ee));
      end
    end
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    // R2
    chk("R2", "addr", 32'(addr_n), 32'h0000);
    chk("R2", "sync/rw/vp/err", {28'd0, s_n, r_n, v_n, e_n}, 32'b0110);
    chk("R2", "phi1/phi2", {30'd0, p1_n, p2_n}, 32'b10);
    chk("R2", "cmos sync/rw/vp/err", {28'd0, s_c, r_c, v_c, e_c}, 32'b0110);
  endtask

  task automatic test_hold_clocks();
    for (int i = 0; i < 3; i++) begin
      tick(8'h00, 8'h00);
      // R1: phase outputs track phase 0 in both halves
      chk("R1", "phi2/phi1 low phase", {30'd0, p2_lo[0], p1_lo[0]}, 32'b01);
      chk("R1", "phi2/phi1 high phase", {30'd0, p2_hi[0], p1_hi[0]}, 32'b10);
      chk("R1", "cmos phi2/phi1 high phase", {30'd0, p2_hi[1], p1_hi[1]}, 32'b10);
      chk("R1", "quiet strobes", {29'd0, s_hi[0], r_hi[0], e_hi[0]}, 32'b010);
    end
    @(negedge clk); res_n = 1'b1;
  endtask

  task automatic pulse_reset();
    @(negedge clk); res_n = 1'b0;
    @(negedge clk);
    // R1: quiet within one clock
    chk("R1", "sync/rw/err after reset drop", {29'd0, s_n, r_n, e_n}, 32'b010);
    chk("R1", "cmos sync/rw/err after reset drop", {29'd0, s_c, r_c, e_c}, 32'b010);
    tick(8'h00, 8'h00);
    tick(8'h00, 8'h00);
    @(negedge clk); res_n = 1'b1;
  endtask

  task automatic test_first_boot();
    run_boot(16'h0000, 16'h8000, 8'hFD, 8'hFD, 13, 1'b0);
  endtask

  task automatic test_second_boot();
    pulse_reset();
    // R5: stack pointer continues from FA; R9: 00FF -> 0100 carry
    run_boot(16'hC0DE, 16'h00FF, 8'hFA, 8'hFA, 13, 1'b0);
  endtask

  task automatic test_bad_opcode();
    pulse_reset();
    run_boot(16'h2000, 16'h3456, 8'hF7, 8'hF7, 12, 1'b1);
    // R10: cleared by reset
    pulse_reset();
    chk("R10", "err cleared by reset", {30'd0, e_n, e_c}, 32'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_state();
    @(negedge clk); rst = 1'b0;
    test_hold_clocks();
    test_first_boot();
    test_second_boot();
    test_bad_opcode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule